// File: doc/BRIEF.md
# Low-Toggle Five-State Controller with Gated Scan Chain

This controller cycles through five states along a fixed transition graph. Its three state bits are encoded so that nearly every legal move flips only one of them, which keeps switching in the next-state and output logic low. A one-bit direction input picks between the two successors of the home state. Every other state has a single successor and advances on every functional clock.

The three state flops also form one scan chain. When scan enable is high they shift serially from `scan_in` to `scan_out`. A mode select picks the kind of cell. In low-power mode, each cell keeps a logic-facing copy of its bit that freezes while the chain shifts. The decode logic and the one-hot output then stay quiet while the chain ripples. On the first clock after scan enable drops, the copy picks up the shifted-in state, and the machine advances from that state on the clock after. In plain mode the logic reads the flops directly, so it sees every intermediate shift pattern.

Top module: `lowtog_scan_fsm`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the state to 000 and the logic-facing copy to 000. After reset `state_q` is 000, `state_hot` is 5'b00001 and `scan_out` is 0.
- R2: The five states are encoded as S1=000, S2=011, S3=001, S4=010 and S5=100. `state_hot` drives bit 0 for S1, bit 1 for S2, bit 2 for S3, bit 3 for S4 and bit 4 for S5, and is all zeros for any other code. It is decoded from the logic-facing view of the state.
- R3: In functional mode, S1 moves to S3 when `dir` is 0 and to S5 when `dir` is 1.
- R4: In functional mode, S3 moves to S2, S2 moves to S4, S4 moves to S1 and S5 moves to S4, whatever the value of `dir`.
- R5: In functional mode, the codes 101, 110 and 111 move to S1 on the next clock.
- R6: While `scan_en` is 1, each clock shifts the chain: bit 0 loads `scan_in`, bit 1 loads bit 0, bit 2 loads bit 1. `scan_out` always equals bit 2 of `state_q`.
- R7: With `lp_mode` 1, `state_hot` does not change during any clock that shifts the chain.
- R8: With `lp_mode` 1, on the first clock after `scan_en` falls the state flops hold, and the logic view loads the shifted-in state (visible on `state_hot`). From the next clock on, the machine advances from that state.
- R9: With `lp_mode` 0, `state_hot` follows every shifted value of the flops. The first clock after `scan_en` falls already advances from the shifted-in state.
- R10: Every legal functional transition changes exactly one state bit, except S5 to S4, which changes two.
- R11: Reset takes priority over scan shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | Successor choice out of S1 (0 to S3, 1 to S5) |
| scan_en | input | 1 | 1 shifts the chain, 0 runs the machine |
| lp_mode | input | 1 | 1 selects cells with a frozen logic-facing copy |
| scan_in | input | 1 | Serial input to chain bit 0 |
| scan_out | output | 1 | Serial output, chain bit 2 |
| state_q | output | 3 | State flop contents |
| state_hot | output | 5 | One-hot decode of the logic-facing state |

## Verification
The bench shifts in patterns that pass through codes with no legal meaning, such as 101 and 110. In low-power mode `state_hot` must not move during those shifts. A design that forgot the gating would pulse the decode, and one that gated the flops instead of the copy would break the chain. Leaving scan mode in low-power mode is checked on both clocks. A design that skipped the reload would resume from the stale frozen state. A design that advanced at once would decode from the stale copy. The bench also drives illegal codes into the functional path, where a wrong design would stick or wander instead of returning to S1. It unloads a state through `scan_out` to check the bit order of the chain.

// File: rtl/lowtog_scan_fsm.sv
module lowtog_scan_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       dir,
  input  logic       scan_en,
  input  logic       lp_mode,
  input  logic       scan_in,
  output logic       scan_out,
  output logic [2:0] state_q,
  output logic [4:0] state_hot
);
  localparam logic [2:0] ST1 = 3'b000;
  localparam logic [2:0] ST2 = 3'b011;
  localparam logic [2:0] ST3 = 3'b001;
  localparam logic [2:0] ST4 = 3'b010;
  localparam logic [2:0] ST5 = 3'b100;

  logic [2:0] flop, held, view, nxt, flop_d;
  logic       se_d, resume;

  assign view   = lp_mode ? held : flop;
  assign resume = lp_mode & se_d & ~scan_en;

  always_comb begin
    case (view)
      ST1:     nxt = dir ? ST5 : ST3;
      ST3:     nxt = ST2;
      ST2:     nxt = ST4;
      ST4:     nxt = ST1;
      ST5:     nxt = ST4;
      default: nxt = ST1;
    endcase
  end

  always_comb begin
    if (scan_en)     flop_d = {flop[1:0], scan_in};
    else if (resume) flop_d = flop;
    else             flop_d = nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flop <= ST1;
      held <= ST1;
      se_d <= 1'b0;
    end else begin
      flop <= flop_d;
      se_d <= scan_en;
      if (!(lp_mode && scan_en))
        held <= resume ? flop : flop_d;
    end
  end

  always_comb begin
    case (view)
      ST1:     state_hot = 5'b00001;
      ST2:     state_hot = 5'b00010;
      ST3:     state_hot = 5'b00100;
      ST4:     state_hot = 5'b01000;
      ST5:     state_hot = 5'b10000;
      default: state_hot = 5'b00000;
    endcase
  end

  assign state_q  = flop;
  assign scan_out = flop[2];

  a_r11_reset_wins: assert property (@(posedge clk) rst |=> state_q == 3'b000);

  a_r6_shift: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> state_q == {$past(state_q[1:0]), $past(scan_in)});

  a_r7_hot_frozen: assert property (@(posedge clk) disable iff (rst)
    (lp_mode && scan_en && $past(lp_mode && scan_en) && $past(!rst)) |-> $stable(state_hot));

  a_r8_resume_hold: assert property (@(posedge clk) disable iff (rst)
    resume |=> ($stable(state_q) && held == state_q));

  a_r5_illegal: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !resume && (view == 3'b101 || view[2:1] == 2'b11)) |=> state_q == 3'b000);

  a_r10_one_bit: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !resume && view != ST5 && (view == ST1 || view == ST2 || view == ST3 || view == ST4))
      |=> $countones(state_q ^ $past(view)) == 1);

  a_r2_hot_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(state_hot));
endmodule

// File: tb/tb_lowtog_scan_fsm.sv
module tb_lowtog_scan_fsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir = 1'b0;
  logic       scan_en = 1'b0;
  logic       lp_mode = 1'b0;
  logic       scan_in = 1'b0;
  logic       scan_out;
  logic [2:0] state_q;
  logic [4:0] state_hot;
  int checks = 0;
  int errors = 0;

  lowtog_scan_fsm dut (.clk(clk), .rst(rst), .dir(dir), .scan_en(scan_en), .lp_mode(lp_mode),
                       .scan_in(scan_in), .scan_out(scan_out), .state_q(state_q), .state_hot(state_hot));

  always #5 clk = ~clk;

  // {dir, expected state after the clock}, starting from S1
  localparam logic [3:0] WALK [10] = '{
    4'b0_001, 4'b0_011, 4'b1_010, 4'b0_000, 4'b1_100,
    4'b0_010, 4'b1_000, 4'b1_100, 4'b1_010, 4'b0_000};

  function automatic logic [4:0] hot_of(input logic [2:0] s);
    case (s)
      3'b000: return 5'b00001;
      3'b011: return 5'b00010;
      3'b001: return 5'b00100;
      3'b010: return 5'b01000;
      3'b100: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic r, input logic d, input logic se, input logic si, input logic lp);
    @(negedge clk);
    rst = r; dir = d; scan_en = se; scan_in = si; lp_mode = lp;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] prev_hot;
    int toggles;
    do_reset();
    do_reset();
    chk("R1 state", {5'b0, state_q}, 8'h00);
    chk("R1 hot", {3'b0, state_hot}, 8'h01);
    chk("R1 scan_out", {7'b0, scan_out}, 8'h00);

    for (int i = 0; i < 10; i++) begin
      tick(1'b0, WALK[i][3], 1'b0, 1'b0, i[0]);
      chk("R3/R4 walk state", {5'b0, state_q}, {5'b0, WALK[i][2:0]});
      chk("R2 walk hot", {3'b0, state_hot}, {3'b0, hot_of(WALK[i][2:0])});
    end

    // R7: low-power shift through 001, 010, 101 must not move state_hot
    do_reset();
    toggles = 0;
    prev_hot = state_hot;
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6 shift1", {5'b0, state_q}, 8'h01);
    if (state_hot != prev_hot) toggles++;
    tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R6 shift2", {5'b0, state_q}, 8'h02);
    if (state_hot != prev_hot) toggles++;
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6 shift3", {5'b0, state_q}, 8'h05);
    chk("R6 scan_out", {7'b0, scan_out}, 8'h01);
    if (state_hot != prev_hot) toggles++;
    chk("R7 hot toggles in lp shift", toggles[7:0], 8'd0);
    chk("R7 hot frozen", {3'b0, state_hot}, 8'h01);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 resume holds", {5'b0, state_q}, 8'h05);
    chk("R8 resume loads view", {3'b0, state_hot}, 8'h00);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 101 to S1", {5'b0, state_q}, 8'h00);

    // R8 with a legal captured state: S2 then S4
    do_reset();
    tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R7 hot still S1", {3'b0, state_hot}, 8'h01);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R8 capture S2 state", {5'b0, state_q}, 8'h03);
    chk("R8 capture S2 hot", {3'b0, state_hot}, 8'h02);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R8 advance to S4", {5'b0, state_q}, 8'h02);

    // R9: plain mode, hot follows the shift
    do_reset();
    toggles = 0;
    prev_hot = state_hot;
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 hot 001", {3'b0, state_hot}, 8'h04);
    if (state_hot != prev_hot) toggles++;
    prev_hot = state_hot;
    tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 hot 010", {3'b0, state_hot}, 8'h08);
    if (state_hot != prev_hot) toggles++;
    prev_hot = state_hot;
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 hot 101", {3'b0, state_hot}, 8'h00);
    if (state_hot != prev_hot) toggles++;
    chk("R9 hot toggles in plain shift", toggles[7:0], 8'd3);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 direct advance", {5'b0, state_q}, 8'h00);

    // R5: 110 and 111
    do_reset();
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 load 110", {5'b0, state_q}, 8'h06);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 110 to S1", {5'b0, state_q}, 8'h00);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6 load 111", {5'b0, state_q}, 8'h07);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 111 to S1", {5'b0, state_q}, 8'h00);

    // R6 unload order from S3 (001): scan_out 0, 1, 0
    do_reset();
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 S1 to S3", {5'b0, state_q}, 8'h01);
    tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 unload 1", {7'b0, scan_out}, 8'h00);
    tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 unload 2", {7'b0, scan_out}, 8'h01);
    tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 unload 3", {7'b0, scan_out}, 8'h00);

    // R10: S5 to S4 flips two bits, S1 to S3 flips one
    do_reset();
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    prev_hot = {2'b0, state_q};
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 S5 to S4 bits", 8'($countones(prev_hot[2:0] ^ state_q)), 8'd2);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    prev_hot = {2'b0, state_q};
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 S1 to S3 bits", 8'($countones(prev_hot[2:0] ^ state_q)), 8'd1);

    // R11: reset while shifting
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R11 reset over scan", {5'b0, state_q}, 8'h00);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1 copy reset", {3'b0, state_hot}, 8'h04);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule